// File: doc/BRIEF.md
# Converter Start-up and Protection Supervisor

This block decides who drives the power switches of a switching DC/DC converter and when switching has to be held off entirely. Comparators and sensors elsewhere in the chip supply it with digitised flags. These report whether the input supply is adequate, whether the output has climbed high enough for closed-loop regulation, whether it has sagged below the regulation minimum or below the hard lockout level, and whether the die is too hot. The block also receives the shutdown pin and whether the digital loop is running in fixed-frequency (PWM) or pulse-skipping (PFM) operation. From these it enables either the free-running boost start-up oscillator or the digital regulation loop, or it raises a global switch-off.

Undervoltage is handled in two stages. A sag below the regulation minimum drops the converter back to start-up pulsing. A collapse below the lockout level stops all switching, and the only way out of that stop is through start-up again. Over-temperature only halts the converter while it runs in PWM operation, and switching resumes as soon as the flag clears. The shutdown input overrides everything in the same cycle.

The block also generates the switching time base as a single-cycle strobe per period. If no edges arrive on the external sync input, the period is a fixed number of system clocks. Once sync edges are seen, the period becomes exactly 22 sync edges. The change of source happens only at a period boundary. If the edges stop for a timeout window, the block drops back to the internal count and starts a fresh period.

Top module: `conv_supervisor`

## Requirements
- R1: After reset, the supervisor is in the start-up state: `loop_en`=0 and `switch_off`=0.
- R2: `boot_osc_en` is 1 only in the start-up state, only while `in_supply_ok`=1 and only while `shutdown`=0. It reacts to `in_supply_ok` in the same cycle.
- R3: In start-up, if `out_reg_ok`=1 and the lockout flag is clear, control passes to the regulation loop on the next clock. From then on `loop_en`=1 and `boot_osc_en`=0.
- R4: In regulation, `out_under_min`=1 (with lockout clear) returns the supervisor to start-up on the next clock.
- R5: `out_under_lock`=1 in start-up, regulation or thermal hold enters lockout on the next clock. In lockout `switch_off`=1 and both enables are 0.
- R6: Lockout ends only when `out_under_lock` clears, and it always leads to start-up, never straight to regulation, even when `out_under_lock` clears while `out_reg_ok`=1.
- R7: `shutdown`=1 forces `switch_off`=1 and both enables to 0 in the same cycle, whatever the state.
- R8: When `shutdown` returns to 0, the sequence restarts from start-up.
- R9: In regulation, `over_temp`=1 with `pwm_active`=1 enters thermal hold (`switch_off`=1) on the next clock. With `pwm_active`=0, `over_temp` has no effect and `loop_en` stays 1.
- R10: Thermal hold returns to regulation on the clock after `over_temp` clears.
- R11: With no sync edges, `period_strobe` pulses for one cycle every INT_DIV system clocks (default 100), and `ext_clk_sel`=0.
- R12: With a steady external sync clock, `ext_clk_sel`=1 and `period_strobe` pulses once every 22 rising sync edges.
- R13: `ext_clk_sel` rises only together with a `period_strobe` pulse after sync edges have been seen. It falls once SYNC_TO (default 64) system clocks pass without a sync edge, and it stays 1 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_supply_ok | input | 1 | Input supply high enough to start pulsing |
| out_reg_ok | input | 1 | Output high enough for closed-loop regulation |
| out_under_min | input | 1 | Output below the regulation minimum |
| out_under_lock | input | 1 | Output below the absolute lockout level |
| shutdown | input | 1 | Shutdown request, active high |
| over_temp | input | 1 | Die over-temperature flag |
| pwm_active | input | 1 | 1 = loop in PWM operation, 0 = PFM |
| sync_clk_in | input | 1 | External sync clock, tied low when unused |
| boot_osc_en | output | 1 | Enable for the start-up oscillator driving the N switch |
| loop_en | output | 1 | Enable for the digital regulation loop |
| switch_off | output | 1 | Global disable of both power switches |
| period_strobe | output | 1 | One-cycle pulse at each switching period boundary |
| ext_clk_sel | output | 1 | 1 while the time base follows the external sync clock |

## Verification
A wrong control state shows up at the enable and disable outputs no more than one clock after the flag that should have moved it. This is because every output is decoded directly from the registered state and the live shutdown and supply flags. The riskiest paths are the ones that skip a step, such as going straight from lockout to regulation, or acting on over-temperature during PFM. The bench drives flag combinations that tempt exactly those shortcuts. Time-base faults surface as a wrong spacing between strobes, which takes one or two full periods to see, or as the source select changing off a period boundary or at the wrong point in the timeout.

// File: rtl/conv_sup_pkg.sv
package conv_sup_pkg;

  typedef enum logic [2:0] {
    SUP_BOOT = 3'd0,
    SUP_RUN  = 3'd1,
    SUP_HOT  = 3'd2,
    SUP_LOCK = 3'd3,
    SUP_OFF  = 3'd4
  } sup_state_e;

  typedef struct packed {
    logic supply_ok;
    logic reg_ok;
    logic under_min;
    logic under_lock;
    logic shdn;
    logic hot;
    logic pwm;
  } sup_flags_t;

endpackage

// File: rtl/conv_sup_fsm.sv
module conv_sup_fsm
  import conv_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sup_flags_t flags,
  output logic       boot_en,
  output logic       run_en,
  output logic       sw_off
);

  sup_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (flags.shdn) begin
      state_d = SUP_OFF;
    end else begin
      unique case (state_q)
        SUP_OFF:  state_d = SUP_BOOT;
        SUP_BOOT: if (flags.under_lock)     state_d = SUP_LOCK;
                  else if (flags.reg_ok)    state_d = SUP_RUN;
        SUP_RUN:  if (flags.under_lock)     state_d = SUP_LOCK;
                  else if (flags.under_min) state_d = SUP_BOOT;
                  else if (flags.hot && flags.pwm) state_d = SUP_HOT;
        SUP_HOT:  if (flags.under_lock)     state_d = SUP_LOCK;
                  else if (!flags.hot)      state_d = SUP_RUN;
        SUP_LOCK: if (!flags.under_lock)    state_d = SUP_BOOT;
        default:  state_d = SUP_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SUP_BOOT;
    else        state_q <= state_d;
  end

  always_comb begin
    boot_en = !flags.shdn && flags.supply_ok && (state_q == SUP_BOOT);
    run_en  = !flags.shdn && (state_q == SUP_RUN);
    sw_off  = flags.shdn || (state_q == SUP_LOCK) || (state_q == SUP_HOT) ||
              (state_q == SUP_OFF);
  end

  AST_BOOT_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_BOOT && !flags.shdn && !flags.under_lock && flags.reg_ok)
      |=> (state_q == SUP_RUN)); // R3

  AST_UNDER_MIN_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_RUN && !flags.shdn && !flags.under_lock && flags.under_min)
      |=> (state_q == SUP_BOOT)); // R4

  AST_LOCK_EXIT_VIA_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_LOCK && !flags.shdn && !flags.under_lock)
      |=> (state_q == SUP_BOOT)); // R6

  AST_SHDN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    flags.shdn |=> (state_q == SUP_OFF)); // R7

  AST_PFM_IGNORES_HEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_RUN && !flags.shdn && !flags.under_lock && !flags.under_min &&
     !flags.pwm) |=> (state_q == SUP_RUN)); // R9

  AST_HOT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_HOT && !flags.shdn && !flags.under_lock && !flags.hot)
      |=> run_en || flags.shdn); // R10

endmodule

// File: rtl/conv_sup_timebase.sv
module conv_sup_timebase #(
  parameter int INT_DIV  = 100,
  parameter int SYNC_DIV = 22,
  parameter int SYNC_TO  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  output logic strobe,
  output logic ext_sel
);

  localparam int MAXDIV = (INT_DIV > SYNC_DIV) ? INT_DIV : SYNC_DIV;
  localparam int CW     = $clog2(MAXDIV);
  localparam int TW     = $clog2(SYNC_TO + 1);
  localparam logic [CW-1:0] INT_LIM  = CW'(INT_DIV - 1);
  localparam logic [CW-1:0] SYNC_LIM = CW'(SYNC_DIV - 1);
  localparam logic [TW-1:0] TO_LIM   = TW'(SYNC_TO - 1);
  localparam logic [TW-1:0] TO_MAX   = TW'(SYNC_TO);

  logic          s_meta, s_sync, s_prev;
  logic          edge_seen;
  logic [TW-1:0] idle_q, idle_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ext_q, ext_d, pend_q, pend_d, tick_q, tick_d;
  logic          adv, wrap, lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= sync_raw;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  assign edge_seen = s_sync && !s_prev;

  always_comb begin
    idle_d = idle_q;
    if (edge_seen)             idle_d = '0;
    else if (idle_q != TO_MAX) idle_d = idle_q + 1'b1;

    adv  = ext_q ? edge_seen : 1'b1;
    wrap = adv && (cnt_q == (ext_q ? SYNC_LIM : INT_LIM));
    lost = ext_q && !edge_seen && (idle_q == TO_LIM);

    pend_d = pend_q;
    if (ext_q)                  pend_d = 1'b0;
    else if (edge_seen)         pend_d = 1'b1;
    else if (idle_q == TO_LIM)  pend_d = 1'b0;

    ext_d  = ext_q;
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (lost) begin
      ext_d = 1'b0;
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d  = '0;
      tick_d = 1'b1;
      if (!ext_q) begin
        ext_d  = pend_q;
        pend_d = 1'b0;
      end
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= TO_MAX;
      cnt_q  <= '0;
      ext_q  <= 1'b0;
      pend_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      pend_q <= pend_d;
      tick_q <= tick_d;
    end
  end

  assign strobe  = tick_q;
  assign ext_sel = ext_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R11

  AST_EXT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_q) |-> tick_q); // R13

  AST_LOSS_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_q) |-> ($past(idle_q) == TO_LIM)); // R13

  AST_EXT_COUNTS_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !edge_seen && !lost) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/conv_supervisor.sv
module conv_supervisor
  import conv_sup_pkg::*;
#(
  parameter int INT_DIV  = 100,
  parameter int SYNC_DIV = 22,
  parameter int SYNC_TO  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_supply_ok,
  input  logic out_reg_ok,
  input  logic out_under_min,
  input  logic out_under_lock,
  input  logic shutdown,
  input  logic over_temp,
  input  logic pwm_active,
  input  logic sync_clk_in,
  output logic boot_osc_en,
  output logic loop_en,
  output logic switch_off,
  output logic period_strobe,
  output logic ext_clk_sel
);

  sup_flags_t flags;

  always_comb begin
    flags.supply_ok  = in_supply_ok;
    flags.reg_ok     = out_reg_ok;
    flags.under_min  = out_under_min;
    flags.under_lock = out_under_lock;
    flags.shdn       = shutdown;
    flags.hot        = over_temp;
    flags.pwm        = pwm_active;
  end

  conv_sup_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .boot_en (boot_osc_en),
    .run_en  (loop_en),
    .sw_off  (switch_off)
  );

  conv_sup_timebase #(
    .INT_DIV  (INT_DIV),
    .SYNC_DIV (SYNC_DIV),
    .SYNC_TO  (SYNC_TO)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_raw (sync_clk_in),
    .strobe   (period_strobe),
    .ext_sel  (ext_clk_sel)
  );

  AST_ENABLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_off |-> !(boot_osc_en || loop_en)); // R5

endmodule

// File: tb/tb_conv_supervisor.sv
`timescale 1ns/1ps
module tb_conv_supervisor;

  localparam int INT_DIV = 100;
  localparam int SYNC_TO = 64;
  localparam int SYNC_HALF = 5;

  logic clk, rst_n;
  logic in_supply_ok, out_reg_ok, out_under_min, out_under_lock;
  logic shutdown, over_temp, pwm_active, sync_clk_in;
  logic boot_osc_en, loop_en, switch_off, period_strobe, ext_clk_sel;

  int errors = 0;
  int checks = 0;
  int m_st = 0;  // 0 boot, 1 run, 2 hot, 3 lock, 4 off
  logic sync_on = 1'b0;
  longint cyc = 0;
  longint last_tick = 0;
  int last_gap = 0;
  int n_ticks = 0;
  bit done = 0;

  conv_supervisor dut (
    .clk(clk), .rst_n(rst_n), .in_supply_ok(in_supply_ok), .out_reg_ok(out_reg_ok),
    .out_under_min(out_under_min), .out_under_lock(out_under_lock),
    .shutdown(shutdown), .over_temp(over_temp), .pwm_active(pwm_active),
    .sync_clk_in(sync_clk_in), .boot_osc_en(boot_osc_en), .loop_en(loop_en),
    .switch_off(switch_off), .period_strobe(period_strobe), .ext_clk_sel(ext_clk_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    sync_clk_in = 1'b0;
    forever begin
      @(negedge clk);
      for (int k = 1; k < SYNC_HALF; k++) @(negedge clk);
      sync_clk_in = sync_on ? ~sync_clk_in : 1'b0;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && period_strobe) begin
      last_gap  <= int'(cyc - last_tick);
      last_tick <= cyc;
      n_ticks   <= n_ticks + 1;
    end
  end

  function automatic int f_next(int st, logic [6:0] v);
    // v = {supply, regok, undermin, underlock, shdn, hot, pwm}
    if (v[2]) return 4;
    case (st)
      4: return 0;
      0: return v[3] ? 3 : (v[5] ? 1 : 0);
      1: return v[3] ? 3 : (v[4] ? 0 : ((v[1] && v[0]) ? 2 : 1));
      2: return v[3] ? 3 : (!v[1] ? 1 : 2);
      default: return v[3] ? 3 : 0;
    endcase
  endfunction

  function automatic logic [2:0] f_out(int st, logic [6:0] v);
    logic b, r, o;
    b = !v[2] && v[6] && st == 0;
    r = !v[2] && st == 1;
    o = v[2] || st == 2 || st == 3 || st == 4;
    return {b, r, o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] v, input string tag);
    @(negedge clk);
    {in_supply_ok, out_reg_ok, out_under_min, out_under_lock,
     shutdown, over_temp, pwm_active} = v;
    #1;
    check(tag, {29'd0, boot_osc_en, loop_en, switch_off}, {29'd0, f_out(m_st, v)});
    m_st = f_next(m_st, v);
  endtask

  task automatic wait_ticks(input int k);
    int start;
    start = n_ticks;
    while (n_ticks < start + k) @(negedge clk);
  endtask

  function automatic string rand_tag(int st, logic [6:0] v);
    if (v[2]) return "R7";
    case (st)
      0: return v[3] ? "R5" : "R3";
      1: return "R4";
      2: return "R10";
      3: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    {in_supply_ok, out_reg_ok, out_under_min, out_under_lock,
     shutdown, over_temp, pwm_active} = 7'b1000000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset enables", {30'd0, loop_en, switch_off}, 32'd0);
    check("R2 boot osc after reset", {31'd0, boot_osc_en}, 32'd1);
    step(7'b0000000, "R2 supply low");
    step(7'b1100000, "R3 reg ok");
    step(7'b1000010, "R9 pfm heat");
    step(7'b1000011, "R9 pwm heat");
    step(7'b1000011, "R9 hold");
    step(7'b1000000, "R10 cool");
    step(7'b1010000, "R4 undermin");
    step(7'b1100000, "R3 reenter");
    step(7'b1001000, "R5 lock");
    step(7'b1101000, "R5 lock hold");
    step(7'b1100000, "R6 exit lock");
    step(7'b1100000, "R6 then run");
    step(7'b1100100, "R7 shdn");
    step(7'b1100100, "R7 shdn hold");
    step(7'b1100000, "R8 release");
    step(7'b1100000, "R8 then run");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 2000; i++) begin
      logic [6:0] v;
      v[6] = ($urandom % 4) != 0;
      v[5] = ($urandom % 3) == 0;
      v[4] = ($urandom % 6) == 0;
      v[3] = ($urandom % 15) == 0;
      v[2] = ($urandom % 30) == 0;
      v[1] = ($urandom % 5) == 0;
      v[0] = ($urandom % 2) == 0;
      step(v, rand_tag(m_st, v));
    end

    wait_ticks(3);
    check("R11 internal period", last_gap, INT_DIV);
    check("R11 internal select", {31'd0, ext_clk_sel}, 32'd0);

    sync_on = 1'b1;
    for (int i = 0; i < 600 && !ext_clk_sel; i++) @(negedge clk);
    check("R13 ext acquired", {31'd0, ext_clk_sel}, 32'd1);
    check("R13 switch on strobe", {31'd0, period_strobe}, 32'd1);
    wait_ticks(3);
    check("R12 sync period", last_gap, 22 * 2 * SYNC_HALF);
    wait_ticks(1);
    check("R12 sync period again", last_gap, 22 * 2 * SYNC_HALF);

    sync_on = 1'b0;
    repeat (SYNC_TO / 2) @(negedge clk);
    check("R13 held inside timeout", {31'd0, ext_clk_sel}, 32'd1);
    repeat (SYNC_TO / 2 + 20) @(negedge clk);
    check("R13 dropped after timeout", {31'd0, ext_clk_sel}, 32'd0);
    wait_ticks(3);
    check("R11 internal after loss", last_gap, INT_DIV);
    done = 1;
  end

  initial begin
    for (int w = 0; w < 150000 && !done; w++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule